// File: doc/BRIEF.md
# Single-wire return-to-one serial responder

This block is the device end of a one-wire, open-drain, return-to-one serial link in front of a small byte-wide register file. The host starts every bit by pulling the line low. The length of that low pulse carries the bit value. A very long low pulse is a break, which puts the link back into a known state. After a break the line must stay high for a recovery time before a command is accepted.

A command byte selects one register and says whether it is written or read. A write command is followed by one data byte from the host. A read command is answered by the block after a fixed turnaround time. The block sends the register's eight bits with the same bit framing, driving the line only through an open-drain pull-down enable. A local port loads and reads the registers directly.

All timings are counted in clock cycles and set by parameters. The defaults are: bit cycle 40, start low 8, stop time 28, break 100, recovery 30, mid-byte high limit 60, turnaround 50.

Top module: `swire_responder`

## Requirements
- R1: A line held low for BREAK_CYC cycles or more is a break, whatever the current state. It discards any partial byte, stops any reply and releases `line_pull` on the next cycle.
- R2: After a break, low pulses are ignored until the line has been high without interruption for RECOV_CYC cycles. Only then is a command accepted.
- R3: Each received bit is one low pulse. A pulse shorter than BIT_CYC/2 cycles is a 1. A pulse of at least BIT_CYC/2 but under BREAK_CYC cycles is a 0. Bits arrive least-significant first.
- R4: In the command byte, bit 7 = 1 means write and 0 means read; bits 6:0 are the register address. A write command stores the next received byte into that register.
- R5: A read command is answered starting RESP_CYC to RESP_CYC+6 cycles after the host releases the line at the end of the command's last bit. Each reply bit lasts BIT_CYC cycles and starts with a low pulse: T_START cycles for a 1, T_STOP cycles for a 0. Bits go out least-significant first.
- R6: Register 0x73 holding 0x65 is answered with the bit sequence 1,0,1,0,0,1,1,0.
- R7: Addresses at or above NREG (default 120) read as zero over both ports, and writes to them are ignored.
- R8: If the line stays high for MAX_CYC cycles after a byte has started, the partial byte is dropped and the block waits for a new command.
- R9: A break that arrives while a reply is being sent ends the reply, and no further bits of it are driven.
- R10: `loc_rdata` always shows the register at `loc_addr`, and a cycle with `loc_we` high stores `loc_wdata` there.
- R11: Reset clears every register, releases the line and leaves the block ready for a command without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the serial line (asynchronous) |
| line_pull | output | 1 | Open-drain enable; 1 pulls the line low |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 7 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register contents at loc_addr |

## Verification
The assertions check the following on every cycle:
- the line is pulled only while a reply is in progress;
- a break releases the line on the next cycle;
- the block stays in recovery until the line has been quiet long enough;
- a stalled byte is dropped;
- a reply that ends normally has sent exactly eight bits.

Other behaviour needs the bench's scenarios, because it depends on the pulse widths and timing the host produces:
- the decoded byte values and least-significant-first order;
- the turnaround delay and the reply's pulse widths;
- that stray pulses during recovery are ignored;
- that out-of-range addresses read as zero;
- that a reply cut by a break never resumes.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [2:0] {
        ST_RECOV,
        ST_CMD,
        ST_DATA,
        ST_TURN,
        ST_SEND
    } xfer_st_t;

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
    } cmd_t;

    typedef struct packed {
        logic brk;
        logic bit_vld;
        logic bit_val;
        logic rec_ok;
        logic hi_long;
    } line_evt_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.wr   = b[7];
        c.addr = b[6:0];
        return c;
    endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], din};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/swire_rx.sv
module swire_rx
    import swire_pkg::*;
#(
    parameter int BIT_CYC   = 40,
    parameter int BREAK_CYC = 100,
    parameter int RECOV_CYC = 30,
    parameter int MAX_CYC   = 60
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ln,
    output line_evt_t evt
);
    localparam int LW   = $clog2(BREAK_CYC + 1);
    localparam int HW   = $clog2(MAX_CYC + 1);
    localparam int HALF = BIT_CYC / 2;

    logic          prev;
    logic [LW-1:0] lcnt;
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            lcnt <= '0;
            hcnt <= '0;
        end else begin
            prev <= ln;
            if (!ln) begin
                hcnt <= '0;
                if (lcnt != LW'(BREAK_CYC)) lcnt <= lcnt + 1'b1;
            end else begin
                lcnt <= '0;
                if (hcnt != HW'(MAX_CYC)) hcnt <= hcnt + 1'b1;
            end
        end
    end

    always_comb begin
        evt.brk     = !ln && (lcnt == LW'(BREAK_CYC - 1));
        evt.bit_vld = ln && !prev && (lcnt < LW'(BREAK_CYC));
        evt.bit_val = lcnt < LW'(HALF);
        evt.rec_ok  = hcnt >= HW'(RECOV_CYC);
        evt.hi_long = hcnt == HW'(MAX_CYC);
    end

    // R1: a break is reported once per low period
    assert_single_break_R1: assert property (@(posedge clk) disable iff (rst)
        evt.brk |=> !evt.brk);
    // R3: a decoded bit ends a low pulse, so two cannot be adjacent
    assert_bit_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        evt.bit_vld |=> !evt.bit_vld);
endmodule

// File: rtl/swire_tx.sv
module swire_tx #(
    parameter int BIT_CYC = 40,
    parameter int T_START = 8,
    parameter int T_STOP  = 28
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       abort,
    output logic       drv,
    output logic       busy
);
    localparam int PW = $clog2(BIT_CYC);

    logic [7:0]    sh;
    logic [2:0]    nb;
    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            sh   <= '0;
            nb   <= '0;
            ph   <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            sh   <= byte_in;
            nb   <= '0;
            ph   <= '0;
        end else if (busy) begin
            if (ph == PW'(BIT_CYC - 1)) begin
                ph <= '0;
                sh <= {1'b0, sh[7:1]};
                nb <= nb + 1'b1;
                if (nb == 3'd7) busy <= 1'b0;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign drv = busy && ((ph < PW'(T_START)) || (!sh[0] && (ph < PW'(T_STOP))));

    // R5: every reply bit opens with a low start period
    assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> drv);
    // R5: a reply that is not aborted sends exactly eight bits
    assert_eight_bits_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(abort)) |-> ($past(nb) == 3'd7));
endmodule

// File: rtl/swire_responder.sv
module swire_responder
    import swire_pkg::*;
#(
    parameter int NREG        = 120,
    parameter int BIT_CYC     = 40,
    parameter int T_START     = 8,
    parameter int T_STOP      = 28,
    parameter int BREAK_CYC   = 100,
    parameter int RECOV_CYC   = 30,
    parameter int MAX_CYC     = 60,
    parameter int RESP_CYC    = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic       line_pull,
    input  logic       loc_we,
    input  logic [6:0] loc_addr,
    input  logic [7:0] loc_wdata,
    output logic [7:0] loc_rdata
);
    localparam int         TW     = $clog2(RESP_CYC + 1);
    localparam logic [7:0] NREG_V = 8'(NREG);

    logic          ln;
    line_evt_t     evt;
    xfer_st_t      st;
    logic [2:0]    bcnt;
    logic [7:0]    sh;
    logic [7:0]    byte_done;
    cmd_t          cmd;
    logic [TW-1:0] tcnt;
    logic          tx_start, tx_busy, wr_en;
    logic [7:0]    rd_byte;
    logic [7:0]    regs [NREG];

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(line_in), .q(ln));

    swire_rx #(.BIT_CYC(BIT_CYC), .BREAK_CYC(BREAK_CYC),
               .RECOV_CYC(RECOV_CYC), .MAX_CYC(MAX_CYC)) u_rx (
        .clk(clk), .rst(rst), .ln(ln), .evt(evt));

    swire_tx #(.BIT_CYC(BIT_CYC), .T_START(T_START), .T_STOP(T_STOP)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .byte_in(rd_byte),
        .abort(evt.brk), .drv(line_pull), .busy(tx_busy));

    assign byte_done = {evt.bit_val, sh[7:1]};
    assign tx_start  = (st == ST_TURN) && (tcnt == '0);
    assign wr_en     = (st == ST_DATA) && evt.bit_vld && (bcnt == 3'd7)
                       && ({1'b0, cmd.addr} < NREG_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_CMD;
            bcnt <= '0;
            sh   <= '0;
            cmd  <= '0;
            tcnt <= '0;
        end else if (evt.brk) begin
            st   <= ST_RECOV;
            bcnt <= '0;
        end else begin
            unique case (st)
                ST_RECOV: begin
                    bcnt <= '0;
                    if (evt.rec_ok) st <= ST_CMD;
                end
                ST_CMD, ST_DATA: begin
                    if (evt.bit_vld) begin
                        sh   <= byte_done;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == 3'd7) begin
                            if (st == ST_CMD) begin
                                cmd <= decode_cmd(byte_done);
                                if (byte_done[7]) begin
                                    st <= ST_DATA;
                                end else begin
                                    st   <= ST_TURN;
                                    tcnt <= TW'(RESP_CYC - 1);
                                end
                            end else begin
                                st <= ST_CMD;
                            end
                        end
                    end else if (evt.hi_long && bcnt != '0) begin
                        bcnt <= '0;
                        st   <= ST_CMD;
                    end
                end
                ST_TURN: begin
                    if (tcnt == '0) st <= ST_SEND;
                    else            tcnt <= tcnt - 1'b1;
                end
                ST_SEND: begin
                    if (!tx_busy) st <= ST_CMD;
                end
                default: st <= ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[cmd.addr] <= byte_done;
        end else if (loc_we && ({1'b0, loc_addr} < NREG_V)) begin
            regs[loc_addr] <= loc_wdata;
        end
    end

    always_comb begin
        loc_rdata = ({1'b0, loc_addr} < NREG_V) ? regs[loc_addr] : 8'h00;
        rd_byte   = ({1'b0, cmd.addr} < NREG_V) ? regs[cmd.addr] : 8'h00;
    end

    // R5: the line is pulled only during a reply
    assert_pull_in_send_R5: assert property (@(posedge clk) disable iff (rst)
        line_pull |-> (st == ST_SEND));
    // R1, R9: a break releases the line on the next cycle
    assert_break_release_R1: assert property (@(posedge clk) disable iff (rst)
        evt.brk |=> !line_pull);
    // R2: recovery is left only once the line has been quiet long enough
    assert_recov_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECOV && !evt.rec_ok) |=> (st == ST_RECOV));
    // R4: a line write only follows a write command
    assert_write_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> cmd.wr);
    // R8: a stalled partial byte is dropped
    assert_stall_drop_R8: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_CMD || st == ST_DATA) && evt.hi_long && bcnt != '0 && !evt.brk)
        |=> (bcnt == '0));
endmodule

// File: tb/tb_swire_responder.sv
module tb_swire_responder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       host_low = 1'b0;
    logic       line_pull;
    logic       line;
    logic       loc_we = 1'b0;
    logic [6:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;

    assign line = ~(host_low | line_pull);

    swire_responder dut (
        .clk(clk), .rst(rst), .line_in(line), .line_pull(line_pull),
        .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata));

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int t_rel = 0;
    int starts [8];
    int widths [8];
    logic [7:0] mdl [128];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // {write, addr, data}
    localparam logic [15:0] VEC [9] = '{
        {1'b1, 7'h73, 8'h65},
        {1'b0, 7'h73, 8'h00},
        {1'b1, 7'h00, 8'hFF},
        {1'b1, 7'h77, 8'h5A},
        {1'b0, 7'h77, 8'h00},
        {1'b0, 7'h00, 8'h00},
        {1'b1, 7'h05, 8'hC3},
        {1'b0, 7'h05, 8'h00},
        {1'b0, 7'h7F, 8'h00}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_bit(input logic b);
        host_low = 1'b1;
        wait_cyc(b ? 8 : 28);
        host_low = 1'b0;
        t_rel = cyc;
        wait_cyc(b ? 32 : 12);
    endtask

    task automatic host_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) host_bit(v[i]);
    endtask

    task automatic host_break();
        host_low = 1'b1;
        wait_cyc(120);
        host_low = 1'b0;
        wait_cyc(40);
    endtask

    task automatic get_reply(output logic [7:0] v, output bit ok);
        ok = 1'b1;
        v  = '0;
        for (int i = 0; i < 8; i++) begin
            int n;
            int s;
            n = 0;
            while (line && n < 400) begin @(negedge clk); n++; end
            if (n >= 400) begin ok = 1'b0; return; end
            s = cyc;
            n = 0;
            while (!line && n < 400) begin @(negedge clk); n++; end
            starts[i] = s;
            widths[i] = cyc - s;
            v[i] = (widths[i] < 20);
        end
    endtask

    task automatic line_read(input logic [6:0] a, output logic [7:0] v, output bit ok);
        host_byte({1'b0, a});
        get_reply(v, ok);
        wait_cyc(40);
    endtask

    task automatic line_write(input logic [6:0] a, input logic [7:0] d);
        host_byte({1'b1, a});
        host_byte(d);
        if (a < 7'd120) mdl[a] = d;
        wait_cyc(5);
    endtask

    task automatic loc_peek(input logic [6:0] a, output logic [7:0] v);
        loc_addr = a;
        #1;
        v = loc_rdata;
    endtask

    initial begin
        logic [7:0] v;
        bit ok;
        int cnt;
        for (int i = 0; i < 128; i++) mdl[i] = 8'h00;

        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R11: reset state
        check(line_pull == 1'b0, "R11", "line released after reset", line_pull, 0);
        loc_peek(7'h73, v);
        check(v == 8'h00, "R11", "register cleared by reset", v, 0);
        // R11: ready without a break
        line_read(7'h10, v, ok);
        check(ok && v == 8'h00, "R11", "read right after reset", v, 0);

        // table walk: R3, R4, R7
        for (int k = 0; k < 9; k++) begin
            if (VEC[k][15]) begin
                line_write(VEC[k][14:8], VEC[k][7:0]);
                loc_peek(VEC[k][14:8], v);
                check(v == mdl[VEC[k][14:8]], "R4/R7", "write via local readback",
                      v, mdl[VEC[k][14:8]]);
            end else begin
                line_read(VEC[k][14:8], v, ok);
                check(ok && v == mdl[VEC[k][14:8]], "R3/R7", "line read value",
                      v, mdl[VEC[k][14:8]]);
            end
        end

        // R6 and R5: exact bit sequence, pulse widths and turnaround
        line_read(7'h73, v, ok);
        check(ok && v == 8'h65, "R6", "bit sequence 1,0,1,0,0,1,1,0", v, 8'h65);
        check(starts[0] - t_rel >= 50 && starts[0] - t_rel <= 56, "R5",
              "turnaround cycles", starts[0] - t_rel, 50);
        begin
            bit wok;
            wok = 1'b1;
            for (int i = 0; i < 8; i++) begin
                if (v[i] && (widths[i] < 7 || widths[i] > 9)) wok = 1'b0;
                if (!v[i] && (widths[i] < 27 || widths[i] > 29)) wok = 1'b0;
                if (i > 0 && starts[i] - starts[i-1] != 40) wok = 1'b0;
            end
            check(wok, "R5", "reply pulse widths and spacing", widths[1], 28);
        end

        // R10: local write seen over the line
        @(negedge clk);
        loc_addr = 7'h30; loc_wdata = 8'h3C; loc_we = 1'b1;
        @(negedge clk);
        loc_we = 1'b0;
        mdl[7'h30] = 8'h3C;
        line_read(7'h30, v, ok);
        check(ok && v == 8'h3C, "R10", "local write read over line", v, 8'h3C);

        // R7: local write to unused address ignored
        @(negedge clk);
        loc_addr = 7'h7A; loc_wdata = 8'h99; loc_we = 1'b1;
        @(negedge clk);
        loc_we = 1'b0;
        loc_peek(7'h7A, v);
        check(v == 8'h00, "R7", "unused address reads zero", v, 0);

        // R8: stalled partial byte dropped
        host_bit(1'b1); host_bit(1'b0); host_bit(1'b1);
        wait_cyc(100);
        line_write(7'h10, 8'h11);
        loc_peek(7'h10, v);
        check(v == 8'h11, "R8", "write after stalled byte", v, 8'h11);

        // R1: break mid-command
        host_bit(1'b0); host_bit(1'b1); host_bit(1'b1); host_bit(1'b0);
        host_break();
        line_write(7'h21, 8'h42);
        loc_peek(7'h21, v);
        check(v == 8'h42, "R1", "write after break mid-command", v, 8'h42);

        // R2: stray pulse during recovery ignored
        host_low = 1'b1; wait_cyc(120); host_low = 1'b0;
        wait_cyc(10);
        host_low = 1'b1; wait_cyc(8); host_low = 1'b0;
        wait_cyc(40);
        line_write(7'h20, 8'h77);
        loc_peek(7'h20, v);
        check(v == 8'h77, "R2", "stray pulse in recovery ignored", v, 8'h77);

        // R9: break during reply
        host_byte({1'b0, 7'h73});
        cnt = 0;
        while (line && cnt < 400) begin @(negedge clk); cnt++; end
        wait_cyc(50);
        host_low = 1'b1;
        wait_cyc(120);
        check(line_pull == 1'b0, "R9", "line released by break", line_pull, 0);
        host_low = 1'b0;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (line_pull) cnt++;
        end
        check(cnt == 0, "R9", "no reply bits after break", cnt, 0);
        line_read(7'h00, v, ok);
        check(ok && v == 8'hFF, "R9", "normal read after aborted reply", v, 8'hFF);

        // R11: reset clears registers
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(2);
        loc_peek(7'h00, v);
        check(v == 8'h00, "R11", "reset clears register 0", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule